// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer

This block is a 32-bit up-counting timer behind a simple single-cycle register bus. A programmable prescaler turns the input clock into counting ticks. On each tick the main counter advances until it reaches the auto-reload limit. On the next tick it returns to zero and raises an update event. Reload is done entirely in hardware, so consecutive periods follow each other with no lost cycles and no help from software.

An update event latches a sticky flag in the status register. When both the counter enable and the update interrupt enable are set, it also pulses the interrupt output for one clock. Software clears the flag by writing zero to it. Software can also load the counter directly, and can force a restart through the event register. That restart zeroes the counter and the prescaler and generates an update event.

Top module: `reload_timer`

## Requirements
- R1: After reset every register reads as zero and `irq_o` is low.
- R2: With the enable bit (control offset 0x00, bit 0) set, the counter at offset 0x24 advances once every (P+1) clocks, where P is the prescaler value at offset 0x28.
- R3: When a tick finds the counter equal to the auto-reload value A (offset 0x2C), the counter becomes 0 on that tick and an update event occurs. This gives a period of (A+1)(P+1) clocks with no gap between periods. With A = 0 the counter stays at 0.
- R4: An update event sets the status flag (offset 0x10, bit 0). A bus write to the status register ANDs the written data into it: writing 0 clears the flag and writing 1 leaves it unchanged.
- R5: `irq_o` is high for exactly the one clock after each update event, and only when the enable bit and the interrupt-enable bit (offset 0x0C, bit 0) are both set. Otherwise no pulse occurs, though the flag is still set.
- R6: While the enable bit is 0, both the counter and the internal prescaler count keep their values. A partly completed prescale period resumes where it stopped.
- R7: A write to the counter offset loads the counter at that clock edge, whether the timer is enabled or not. Counting then continues from the loaded value.
- R8: Writing the event register (offset 0x14) with bit 0 set zeroes the counter and the prescaler count and generates an update event. A write with bit 0 clear does nothing. The event register always reads 0.
- R9: Reads from any offset not listed above return 0. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, one write per asserted cycle |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Update interrupt pulse |

## Verification
The assertions take for granted that `we_i` and `addr_i` are at known values from the first clock edge after reset. They also assume at most one write lands per edge, so a counter load and an event-register write never coincide. The stimulus meets both: it drives the bus only from tasks that raise `we_i` between edges and drop it just after the committing edge, one register at a time. It holds `we_i` low through reset.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_EVGEN = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_CNT   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_PSC   = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_ARR   = 8'h2C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_IEN,
    SEL_STAT,
    SEL_EVGEN,
    SEL_CNT,
    SEL_PSC,
    SEL_ARR
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_CTRL:  return SEL_CTRL;
      OFF_IEN:   return SEL_IEN;
      OFF_STAT:  return SEL_STAT;
      OFF_EVGEN: return SEL_EVGEN;
      OFF_CNT:   return SEL_CNT;
      OFF_PSC:   return SEL_PSC;
      OFF_ARR:   return SEL_ARR;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;
  logic             last;

  // >= keeps the divider sane if the limit is lowered mid-period
  assign last   = (div_q >= div_i);
  assign tick_o = en_i && !clr_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (en_i)   div_q <= last ? '0 : div_q + 1'b1;
  end

  assert_hold_div_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(div_q));

  assert_tick_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (div_q == '0));
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = tick_i && !clr_i && !ld_i && (cnt_q == arr_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (ld_i)    cnt_q <= ld_val_i;
    else if (tick_i)  cnt_q <= (cnt_q == arr_i) ? '0 : cnt_q + 1'b1;
  end

  assert_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));

  assert_evgen_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

  assert_hold_cnt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i && !ld_i) |=> $stable(cnt_q));

  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !clr_i) |=> (cnt_q == $past(ld_val_i)));
endmodule

// File: rtl/rt_regs.sv
module rt_regs
  import rt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PSC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              wrap_i,
  output logic              cen_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [DATA_W-1:0] arr_o,
  output logic              cnt_ld_o,
  output logic              evgen_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - PSC_W;

  reg_sel_e          sel;
  logic [DATA_W-1:0] ctrl_q, ien_q, arr_q;
  logic [PSC_W-1:0]  psc_q;
  logic              uif_q, irq_q, upd;

  assign sel      = decode_addr(addr_i);
  assign evgen_o  = we_i && (sel == SEL_EVGEN) && wdata_i[0];
  assign cnt_ld_o = we_i && (sel == SEL_CNT);
  assign upd      = wrap_i || evgen_o;
  assign cen_o    = ctrl_q[0];
  assign psc_o    = psc_q;
  assign arr_o    = arr_q;
  assign irq_o    = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      psc_q  <= '0;
      arr_q  <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_CTRL: ctrl_q <= wdata_i;
        SEL_IEN:  ien_q  <= wdata_i;
        SEL_PSC:  psc_q  <= wdata_i[PSC_W-1:0];
        SEL_ARR:  arr_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  // hardware set wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uif_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (upd)                            uif_q <= 1'b1;
      else if (we_i && sel == SEL_STAT)   uif_q <= uif_q & wdata_i[0];
      irq_q <= upd && ien_q[0] && ctrl_q[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_CTRL: rdata_o = ctrl_q;
      SEL_IEN:  rdata_o = ien_q;
      SEL_STAT: rdata_o = {{(DATA_W-1){1'b0}}, uif_q};
      SEL_CNT:  rdata_o = cnt_i;
      SEL_PSC:  rdata_o = {{PAD_W{1'b0}}, psc_q};
      SEL_ARR:  rdata_o = arr_q;
      default:  rdata_o = '0;
    endcase
  end

  assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> uif_q);

  assert_irq_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> uif_q);

  assert_irq_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_q[0] |=> !irq_q);
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PSC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              cen, tick, wrap, cnt_ld, evgen;
  logic [PSC_W-1:0]  psc;
  logic [DATA_W-1:0] arr, cnt;

  rt_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .cnt_i    (cnt),
    .wrap_i   (wrap),
    .cen_o    (cen),
    .psc_o    (psc),
    .arr_o    (arr),
    .cnt_ld_o (cnt_ld),
    .evgen_o  (evgen),
    .irq_o    (irq_o)
  );

  rt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cen),
    .clr_i  (evgen),
    .div_i  (psc),
    .tick_o (tick)
  );

  rt_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .clr_i    (evgen),
    .ld_i     (cnt_ld),
    .ld_val_i (wdata_i),
    .arr_i    (arr),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );
endmodule

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int cyc = 0;

  localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h0C, A_STAT = 8'h10,
    A_EVG = 8'h14, A_CNT = 8'h24, A_PSC = 8'h28, A_ARR = 8'h2C;

  // prescaler, auto-reload, cycles to run
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{0, 4, 3}, '{0, 4, 5}, '{2, 3, 7}, '{2, 3, 25},
    '{1, 0, 6}, '{0, 9, 23}, '{3, 2, 40}, '{4, 1, 31}
  };

  reload_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (irq) irq_cnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    logic [31:0] v, c0;
    #45 rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    foreach (VEC[i]) begin end
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_IEN, v);  chk("R1 ien", v, 0);
    rd(A_STAT, v); chk("R1 stat", v, 0);
    rd(A_CNT, v);  chk("R1 cnt", v, 0);
    rd(A_PSC, v);  chk("R1 psc", v, 0);
    rd(A_ARR, v);  chk("R1 arr", v, 0);
    chk("R1 irq", irq, 0);

    // R2/R3/R5: vector table
    for (int i = 0; i < NV; i++) begin
      int p, a, n, per;
      p = VEC[i][0]; a = VEC[i][1]; n = VEC[i][2];
      per = (a + 1) * (p + 1);
      wr(A_CTRL, 0);
      wr(A_PSC, p);
      wr(A_ARR, a);
      wr(A_EVG, 1);
      wr(A_STAT, 0);
      wr(A_IEN, 1);
      irq_cnt = 0;
      wr(A_CTRL, 1);
      repeat (n) @(posedge clk);
      @(negedge clk);
      #1;
      rd(A_CNT, v);  chk("R2 R3 count", v, (n / (p + 1)) % (a + 1));
      rd(A_STAT, v); chk("R4 flag", v, (n >= per) ? 1 : 0);
      chk("R5 irq pulses", irq_cnt, n / per);
    end

    // R4: status write ANDs
    wr(A_CTRL, 0);
    rd(A_STAT, v); chk("R4 flag pre", v, 1);
    wr(A_STAT, 1);
    rd(A_STAT, v); chk("R4 write1 keeps", v, 1);
    wr(A_STAT, 0);
    rd(A_STAT, v); chk("R4 write0 clears", v, 0);

    // R6: hold while disabled, prescaler resumes mid-period
    rd(A_CNT, c0);
    wait_cyc(10);
    rd(A_CNT, v); chk("R6 cnt hold", v, c0);
    wr(A_PSC, 3);
    wr(A_ARR, 100);
    wr(A_EVG, 1);
    wr(A_CTRL, 1);
    wr(A_CTRL, 0);
    wait_cyc(20);
    rd(A_CNT, v); chk("R6 cnt hold2", v, 0);
    wr(A_CTRL, 1);
    wait_cyc(2);
    rd(A_CNT, v); chk("R6 resume early", v, 0);
    wait_cyc(1);
    rd(A_CNT, v); chk("R6 resume tick", v, 1);

    // R7: direct counter load
    wr(A_CTRL, 0);
    wr(A_PSC, 0);
    wr(A_CNT, 50);
    rd(A_CNT, v); chk("R7 load disabled", v, 50);
    wr(A_CTRL, 1);
    wait_cyc(5);
    rd(A_CNT, v); chk("R7 count from load", v, 55);
    wr(A_CNT, 7);
    rd(A_CNT, v); chk("R7 load enabled", v, 7);

    // R5: gating by interrupt enable and counter enable
    wr(A_CTRL, 0);
    wr(A_IEN, 0);
    wr(A_ARR, 3);
    wr(A_EVG, 1);
    wr(A_STAT, 0);
    irq_cnt = 0;
    wr(A_CTRL, 1);
    wait_cyc(10);
    rd(A_STAT, v); chk("R5 flag without ien", v, 1);
    chk("R5 no irq without ien", irq_cnt, 0);
    wr(A_CTRL, 0);
    wr(A_IEN, 1);
    wr(A_STAT, 0);
    irq_cnt = 0;
    wr(A_EVG, 1);
    wait_cyc(2);
    rd(A_STAT, v); chk("R8 evgen sets flag", v, 1);
    chk("R5 no irq without cen", irq_cnt, 0);

    // R8: event register
    wr(A_CNT, 33);
    wr(A_EVG, 1);
    rd(A_CNT, v); chk("R8 evgen clears cnt", v, 0);
    rd(A_EVG, v); chk("R8 evgen reads zero", v, 0);
    wr(A_CNT, 9);
    wr(A_EVG, 2);
    rd(A_CNT, v); chk("R8 bit0 clear no effect", v, 9);

    // R9: unmapped offsets
    wr(A_PSC, 5);
    wr(A_ARR, 77);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R9 unmapped read", v, 0);
    rd(8'hFC, v); chk("R9 unmapped read hi", v, 0);
    rd(A_PSC, v); chk("R9 psc kept", v, 5);
    rd(A_ARR, v); chk("R9 arr kept", v, 77);
    rd(A_CTRL, v); chk("R9 ctrl kept", v, 0);
    rd(A_CNT, v); chk("R9 cnt kept", v, 9);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule